// File: doc/BRIEF.md
# Bus Error Machine Check Logger

This block watches the transactions a processor issues on its front-side bus and records the first one that fails. A transaction can fail in two ways. A read data beat can carry bad parity, and that counts only when the platform pulls its active-low parity-enable pin low in the same beat. The platform can also pull an active-low bus-check pin low in the cycle that ends the transaction. When a failure is logged, the block stores three things: the transaction's physical address, its type code and its direction. It also sets a check flag. If the exception enable bit is 1, it raises a machine-check exception request (vector 18) for one cycle.

Software reads the stored error through a register read port that is selected by index. Reading the type register returns its contents and clears the check flag in that same cycle, which frees the logger to capture the next failure. Logging does not depend on the exception enable bit. An error is recorded with the enable bit at 0, and software can later find it by polling.

Top module: `bus_mc_logger`

## Requirements
- R1: After synchronous reset, `mce_req` is 0, the exception enable bit is 0, and register index 0 (address) and index 1 (type) both read 0.
- R2: A read transaction is logged when at least one of its data beats has a parity mismatch while `par_en_n` is 0 in that beat. The parity check is even by default: `beat_par` must equal the XOR of `beat_data`.
- R3: A parity mismatch is ignored in three cases: the beat has `par_en_n` at 1, the transaction is a write (`txn_rd` = 0), or the parity is correct.
- R4: `bchk_n` = 0 in the cycle where `txn_end` is 1 logs the transaction. A low `bchk_n` in any other cycle is ignored.
- R5: A logged error stores the address and type of the transaction that failed. Address register (index 0) holds the address. Type register (index 1) holds check bit at bit 0, the read flag at bit 1, and the type code at bits TYPE_W+1..2; all other bits are 0.
- R6: While the check bit is 1, later errors leave the address and type registers unchanged.
- R7: A read of index 1 returns the old type value and clears the check bit. A read of index 0 does not clear it.
- R8: `mce_req` pulses high for exactly one cycle, in the cycle after `txn_end`. It fires only when an entry is made and the enable bit is 1. With the enable bit at 0, the entry is still made and no pulse occurs.
- R9: A parity error and a bus-check error on the same transaction produce one entry and at most one pulse.
- R10: `msr_rdata` and `msr_rvld` are valid in the cycle after `msr_rd`. Any index other than 0 or 1 reads 0.
- R11: `cfg_we` = 1 loads `cfg_mce_en` into the exception enable bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the exception enable bit |
| cfg_mce_en | input | 1 | New value of the exception enable bit |
| txn_start | input | 1 | Address phase of a new transaction |
| txn_addr | input | ADDR_W | Physical address, sampled with txn_start |
| txn_type | input | TYPE_W | Transaction type code, sampled with txn_start |
| txn_rd | input | 1 | 1 for a read, sampled with txn_start |
| beat_vld | input | 1 | A data beat is on the bus |
| beat_data | input | DATA_W | Data of the beat |
| beat_par | input | 1 | Parity bit of the beat |
| par_en_n | input | 1 | Active-low parity-check enable from the platform |
| txn_end | input | 1 | Final cycle of the open transaction |
| bchk_n | input | 1 | Active-low bus-check, meaningful with txn_end |
| msr_rd | input | 1 | Register read request |
| msr_idx | input | 2 | Register index: 0 address, 1 type |
| msr_rdata | output | ADDR_W | Read data |
| msr_rvld | output | 1 | Read data valid |
| mce_req | output | 1 | Machine-check exception request pulse |

## Verification
Each result settles one edge after its stimulus. An entry and its `mce_req` pulse come from the edge that samples `txn_end`. Read data and the cleared check bit come from the edge that samples `msr_rd`. The enable bit changes at the edge that samples `cfg_we`. The bench drives inputs on the falling edge and samples on the next falling edge, so each check sees the value one rising edge after its cause. It samples `mce_req` again one cycle later to confirm the pulse has ended.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  localparam int IDX_W = 2;

  typedef enum logic [IDX_W-1:0] {
    MCL_IDX_ADDR = 2'd0,
    MCL_IDX_TYPE = 2'd1
  } mcl_idx_e;

  localparam int TYPE_CHK_BIT = 0;
  localparam int TYPE_RD_BIT  = 1;
  localparam int TYPE_LSB     = 2;
endpackage

// File: rtl/mcl_par_chk.sv
module mcl_par_chk #(
  parameter int DATA_W  = 8,
  parameter bit PAR_ODD = 1'b0
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              bad
);
  logic sum;
  assign sum = ^{data, par};

  generate
    if (PAR_ODD) begin : g_odd
      assign bad = ~sum;
    end else begin : g_even
      assign bad = sum;
    end
  endgenerate
endmodule

// File: rtl/mcl_txn_track.sv
module mcl_txn_track #(
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [TYPE_W-1:0] txn_type,
  input  logic              txn_rd,
  input  logic              txn_end,
  input  logic              beat_vld,
  input  logic              beat_bad,
  input  logic              par_en_n,
  input  logic              bchk_n,
  output logic              err_now,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [TYPE_W-1:0] cur_type,
  output logic              cur_rd
);
  logic open_q;
  logic par_pend_q;
  logic beat_hit;
  logic par_fail;
  logic bus_fail;

  assign beat_hit = open_q & beat_vld & beat_bad & ~par_en_n;
  assign par_fail = cur_rd & (par_pend_q | beat_hit);
  assign bus_fail = ~bchk_n;
  assign err_now  = txn_end & open_q & (par_fail | bus_fail);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q     <= 1'b0;
      par_pend_q <= 1'b0;
      cur_addr   <= '0;
      cur_type   <= '0;
      cur_rd     <= 1'b0;
    end else begin
      if (txn_start) begin
        open_q     <= 1'b1;
        par_pend_q <= 1'b0;
        cur_addr   <= txn_addr;
        cur_type   <= txn_type;
        cur_rd     <= txn_rd;
      end else if (txn_end) begin
        open_q     <= 1'b0;
        par_pend_q <= 1'b0;
      end else if (beat_hit) begin
        par_pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcl_log_regs.sv
module mcl_log_regs
  import mcl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              log_req,
  input  logic [ADDR_W-1:0] log_addr,
  input  logic [TYPE_W-1:0] log_type,
  input  logic              log_rd,
  input  logic              mce_en,
  input  logic              msr_rd,
  input  logic [IDX_W-1:0]  msr_idx,
  output logic [ADDR_W-1:0] msr_rdata,
  output logic              msr_rvld,
  output logic              mce_req,
  output logic              chk_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic [TYPE_W-1:0] type_q;
  logic              rd_q;
  logic              clr;
  logic              take;
  logic [ADDR_W-1:0] type_word;
  logic [ADDR_W-1:0] rd_mux;

  assign clr  = msr_rd & (msr_idx == MCL_IDX_TYPE);
  assign take = log_req & (~chk_q | clr);

  always_comb begin
    type_word = '0;
    type_word[TYPE_CHK_BIT] = chk_q;
    type_word[TYPE_RD_BIT]  = rd_q;
    type_word[TYPE_LSB +: TYPE_W] = type_q;
  end

  always_comb begin
    case (msr_idx)
      MCL_IDX_ADDR: rd_mux = addr_q;
      MCL_IDX_TYPE: rd_mux = type_word;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_q     <= 1'b0;
      addr_q    <= '0;
      type_q    <= '0;
      rd_q      <= 1'b0;
      mce_req   <= 1'b0;
      msr_rdata <= '0;
      msr_rvld  <= 1'b0;
    end else begin
      mce_req  <= take & mce_en;
      msr_rvld <= msr_rd;
      if (msr_rd) msr_rdata <= rd_mux;
      if (take) begin
        chk_q  <= 1'b1;
        addr_q <= log_addr;
        type_q <= log_type;
        rd_q   <= log_rd;
      end else if (clr) begin
        chk_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bus_mc_logger.sv
module bus_mc_logger
  import mcl_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TYPE_W  = 3,
  parameter int DATA_W  = 8,
  parameter bit PAR_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_mce_en,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [TYPE_W-1:0] txn_type,
  input  logic              txn_rd,
  input  logic              beat_vld,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              beat_par,
  input  logic              par_en_n,
  input  logic              txn_end,
  input  logic              bchk_n,
  input  logic              msr_rd,
  input  logic [IDX_W-1:0]  msr_idx,
  output logic [ADDR_W-1:0] msr_rdata,
  output logic              msr_rvld,
  output logic              mce_req
);
  logic              mce_en_q;
  logic              beat_bad;
  logic              err_now;
  logic [ADDR_W-1:0] cur_addr;
  logic [TYPE_W-1:0] cur_type;
  logic              cur_rd;
  logic              chk_q;
  logic [ADDR_W-1:0] err_addr_q;

  always_ff @(posedge clk) begin
    if (rst)         mce_en_q <= 1'b0;
    else if (cfg_we) mce_en_q <= cfg_mce_en;
  end

  mcl_par_chk #(.DATA_W(DATA_W), .PAR_ODD(PAR_ODD)) u_par (
    .data (beat_data),
    .par  (beat_par),
    .bad  (beat_bad)
  );

  mcl_txn_track #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .txn_start (txn_start),
    .txn_addr  (txn_addr),
    .txn_type  (txn_type),
    .txn_rd    (txn_rd),
    .txn_end   (txn_end),
    .beat_vld  (beat_vld),
    .beat_bad  (beat_bad),
    .par_en_n  (par_en_n),
    .bchk_n    (bchk_n),
    .err_now   (err_now),
    .cur_addr  (cur_addr),
    .cur_type  (cur_type),
    .cur_rd    (cur_rd)
  );

  mcl_log_regs #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_log (
    .clk       (clk),
    .rst       (rst),
    .log_req   (err_now),
    .log_addr  (cur_addr),
    .log_type  (cur_type),
    .log_rd    (cur_rd),
    .mce_en    (mce_en_q),
    .msr_rd    (msr_rd),
    .msr_idx   (msr_idx),
    .msr_rdata (msr_rdata),
    .msr_rvld  (msr_rvld),
    .mce_req   (mce_req),
    .chk_q     (chk_q),
    .addr_q    (err_addr_q)
  );
endmodule

// File: rtl/mcl_checker.sv
module mcl_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mce_req,
  input logic              chk,
  input logic              en,
  input logic              txn_end,
  input logic              msr_rd,
  input logic [1:0]        msr_idx,
  input logic              msr_rvld,
  input logic [ADDR_W-1:0] err_addr
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mce_req |=> !mce_req); // R8

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    mce_req |-> $past(en)); // R8

  AST_REQ_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    mce_req |-> chk); // R9

  AST_LOG_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(chk) |-> $past(txn_end)); // R4

  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (rst)
    (chk && $past(chk) && !$past(msr_rd && msr_idx == 2'd1)) |-> $stable(err_addr)); // R6

  AST_TYPE_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (msr_rd && msr_idx == 2'd1 && !txn_end) |=> !chk); // R7

  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    msr_rd |=> msr_rvld); // R10
endmodule

bind bus_mc_logger mcl_checker #(.ADDR_W(ADDR_W)) u_mcl_checker (
  .clk      (clk),
  .rst      (rst),
  .mce_req  (mce_req),
  .chk      (chk_q),
  .en       (mce_en_q),
  .txn_end  (txn_end),
  .msr_rd   (msr_rd),
  .msr_idx  (msr_idx),
  .msr_rvld (msr_rvld),
  .err_addr (err_addr_q)
);

// File: tb/bus_mc_logger_bench.sv
module bus_mc_logger_bench;
  localparam int ADDR_W = 32;
  localparam int TYPE_W = 3;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_we, cfg_mce_en;
  logic              txn_start, txn_rd, txn_end;
  logic [ADDR_W-1:0] txn_addr;
  logic [TYPE_W-1:0] txn_type;
  logic              beat_vld, beat_par, par_en_n, bchk_n;
  logic [DATA_W-1:0] beat_data;
  logic              msr_rd;
  logic [1:0]        msr_idx;
  logic [ADDR_W-1:0] msr_rdata;
  logic              msr_rvld, mce_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit                m_chk, m_rd, m_en;
  logic [ADDR_W-1:0] m_addr;
  logic [TYPE_W-1:0] m_typ;

  always #2.5 clk = ~clk;

  bus_mc_logger u_bus_mc_logger (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mce_en(cfg_mce_en),
    .txn_start(txn_start), .txn_addr(txn_addr), .txn_type(txn_type), .txn_rd(txn_rd),
    .beat_vld(beat_vld), .beat_data(beat_data), .beat_par(beat_par), .par_en_n(par_en_n),
    .txn_end(txn_end), .bchk_n(bchk_n), .msr_rd(msr_rd), .msr_idx(msr_idx),
    .msr_rdata(msr_rdata), .msr_rvld(msr_rvld), .mce_req(mce_req)
  );

  function automatic logic [ADDR_W-1:0] type_word(bit c, bit r, logic [TYPE_W-1:0] t);
    logic [ADDR_W-1:0] w = '0;
    w[0] = c;
    w[1] = r;
    w[TYPE_W+1:2] = t;
    return w;
  endfunction

  task automatic check(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; txn_start = 0; txn_end = 0; beat_vld = 0;
    par_en_n = 1; bchk_n = 1; msr_rd = 0;
  endtask

  task automatic set_en(bit v, string req);
    @(negedge clk); idle(); cfg_we = 1; cfg_mce_en = v;
    @(negedge clk); idle();
    m_en = v;
  endtask

  task automatic rd_msr(logic [1:0] idx, string req);
    logic [ADDR_W-1:0] exp;
    @(negedge clk); idle(); msr_rd = 1; msr_idx = idx;
    @(negedge clk); idle();
    if (idx == 2'd0)      exp = m_addr;
    else if (idx == 2'd1) exp = type_word(m_chk, m_rd, m_typ);
    else                  exp = '0;
    check(req, msr_rdata, exp);
    check(req, {31'd0, msr_rvld}, 32'd1);
    if (idx == 2'd1) m_chk = 0;
  endtask

  // pe_n / bad: per-beat bits; bchk: bus-check at end; noise: low bchk_n mid-transaction
  task automatic do_txn(logic [ADDR_W-1:0] a, logic [TYPE_W-1:0] t, bit r, int nb,
                        logic [3:0] pe_n, logic [3:0] bad, bit bchk, bit noise, string req);
    bit err = bchk;
    bit pulse;
    @(negedge clk); idle();
    txn_start = 1; txn_addr = a; txn_type = t; txn_rd = r;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); idle();
      beat_vld  = 1;
      beat_data = DATA_W'($urandom);
      beat_par  = (^beat_data) ^ bad[i];
      par_en_n  = pe_n[i];
      if (r && bad[i] && !pe_n[i]) err = 1;
      if (i == nb - 1) begin
        txn_end = 1; bchk_n = ~bchk;
      end else begin
        bchk_n = ~noise;
      end
      txn_addr = ADDR_W'($urandom);
      txn_type = TYPE_W'($urandom);
    end
    @(negedge clk); idle();
    pulse = 0;
    if (err && !m_chk) begin
      m_chk = 1; m_addr = a; m_typ = t; m_rd = r; pulse = m_en;
    end
    check(req, {31'd0, mce_req}, {31'd0, pulse});
    @(negedge clk);
    check("R8", {31'd0, mce_req}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    idle(); cfg_mce_en = 0; txn_addr = '0; txn_type = '0; txn_rd = 0;
    beat_data = '0; beat_par = 0; msr_idx = 0;
    m_chk = 0; m_rd = 0; m_en = 0; m_addr = '0; m_typ = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1", {31'd0, mce_req}, 32'd0);
    rd_msr(2'd0, "R1");
    rd_msr(2'd1, "R1");
    // R1: enable is 0 after reset, so an error gives no pulse
    do_txn(32'h1000_0040, 3'd5, 1, 1, 4'b0000, 4'b0000, 1, 0, "R1");
    rd_msr(2'd1, "R8");            // entry made while enable was 0
    set_en(1, "R11");
    // R2: parity error on 2nd beat with enable low
    do_txn(32'hCAFE_0010, 3'd2, 1, 3, 4'b0000, 4'b0010, 0, 0, "R2");
    rd_msr(2'd0, "R5");
    rd_msr(2'd0, "R7");            // address read keeps check bit
    rd_msr(2'd1, "R5");
    // R3: ignored parity cases
    do_txn(32'h0000_0100, 3'd1, 1, 2, 4'b0011, 4'b0011, 0, 0, "R3");
    do_txn(32'h0000_0200, 3'd3, 0, 2, 4'b0000, 4'b0011, 0, 0, "R3");
    do_txn(32'h0000_0300, 3'd4, 1, 2, 4'b0000, 4'b0000, 0, 0, "R3");
    rd_msr(2'd1, "R3");
    // R4: bus-check low mid-transaction ignored
    do_txn(32'h0000_0400, 3'd6, 0, 3, 4'b1111, 4'b0000, 0, 1, "R4");
    rd_msr(2'd1, "R4");
    do_txn(32'h0000_0500, 3'd7, 0, 2, 4'b1111, 4'b0000, 1, 0, "R4");
    // R6: second error does not overwrite
    do_txn(32'h0000_0600, 3'd1, 1, 1, 4'b0000, 4'b0001, 1, 0, "R6");
    rd_msr(2'd0, "R6");
    rd_msr(2'd1, "R6");
    rd_msr(2'd1, "R7");
    // R9: both errors on one transaction
    do_txn(32'hBEEF_0000, 3'd3, 1, 2, 4'b0000, 4'b0011, 1, 0, "R9");
    rd_msr(2'd1, "R9");
    rd_msr(2'd2, "R10");
    rd_msr(2'd3, "R10");
    // random traffic
    for (int k = 0; k < 300; k++) begin
      int sel = $urandom_range(0, 9);
      if (sel == 0) set_en(1'($urandom), "R11");
      else if (sel < 3) rd_msr(2'($urandom), "R10");
      else do_txn(ADDR_W'($urandom), TYPE_W'($urandom), 1'($urandom), $urandom_range(1, 4),
                  4'($urandom), ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'd0,
                  ($urandom_range(0, 4) == 0), 1'($urandom), "R2");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule